// File: doc/BRIEF.md
# Reference Clock Selector with Loss-of-Signal Monitoring

This block chooses which of four reference clocks feeds a downstream PLL. Every reference is sampled in a faster system clock domain. Each sampled reference passes through a two-flop synchronizer before its rising edges are detected. A missing-edge monitor on each input keeps a loss-of-signal flag up to date.

The source can be chosen in three ways. In manual mode, a 2-bit code comes either from a pair of select pins or from a register field. In automatic revertive mode, the selector always moves to the healthy input with the highest priority. In automatic non-revertive mode, it stays on the current input until that input fails. When every input has failed in an automatic mode, the selection is frozen and a holdover flag is raised.

Each input has an "active" indicator and a "bad" indicator. Each indicator has its own output enable, and each group has a shared polarity. An indicator whose enable is clear is not driven. The indicators for inputs 3 and 4 share their pads with the select pins, so they can only be driven in automatic mode. A register copy of the active status is always available.

Top module: `refclk_selector`

## Requirements
- R1: While reset is held and in the first cycle after it, the following hold: selection code 00, all four loss flags set, holdover low.
- R2: The select codes 00, 01, 10 and 11 name inputs 1, 2, 3 and 4 (bit indices 0 to 3). `sel_o` reports the code, and `act_stat_o` is one-hot on bit `sel_o`, whatever the pin enables are.
- R3: Manual mode is `mode_i` 00 (11 behaves the same). With `pin_sel_en_i`=1 in this mode, `sel_o` takes the value of `sel_pin_i` one clock later, and `reg_sel_i` has no effect.
- R4: With `pin_sel_en_i`=0 in manual mode, `sel_o` takes the value of `reg_sel_i` one clock later, and `sel_pin_i` has no effect.
- R5: An input's loss flag rises once `los_limit_i` consecutive system cycles pass without a synchronized rising edge on it. Edges spaced closer than the limit keep the flag low.
- R6: A set loss flag clears on the `los_clear_i`-th consecutive rising edge that follows the previous one by fewer than `los_limit_i` cycles. The first edge after a loss only restarts the interval.
- R7: In revertive mode (`mode_i`=01), `sel_o` moves one cycle after a flag change to the lowest-numbered input whose loss flag is low. This includes returning to a higher-priority input once it has recovered.
- R8: In non-revertive mode (`mode_i`=10), `sel_o` holds while the selected input is valid. When that input fails, `sel_o` moves to the lowest-numbered valid input.
- R9: In either automatic mode, if all four loss flags are set, `sel_o` is frozen and `holdover_o` is 1. In manual mode, `holdover_o` is 0.
- R10: `act_pin_oe_o[i]` follows `act_en_i[i]`. A driven active pin shows the status bit when `act_pol_i`=1 and its inverse when `act_pol_i`=0. A pin that is not driven reads 0.
- R11: For inputs 3 and 4, whose pads are shared with the select pins, `act_pin_oe_o` is set only when both the enable bit and an automatic mode are active. In manual mode these outputs are always undriven.
- R12: `bad_pin_oe_o[i]` follows `bad_en_i[i]`. A driven bad pin shows the loss flag when `bad_pol_i`=1 and its inverse when `bad_pol_i`=0. A pin that is not driven reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 4 | Asynchronous reference clocks, bit 0 = input 1 |
| mode_i | input | 2 | 00 manual, 01 revertive, 10 non-revertive, 11 manual |
| pin_sel_en_i | input | 1 | Manual source: 1 select pins, 0 register field |
| sel_pin_i | input | 2 | Select code from the shared pads |
| reg_sel_i | input | 2 | Select code from the register field |
| los_limit_i | input | CNT_W | Idle cycles that declare loss of signal |
| los_clear_i | input | CLR_W | Good intervals needed to clear a loss |
| act_en_i | input | 4 | Per-input enable of the active indicator |
| act_pol_i | input | 1 | Active indicator polarity, 1 = active high |
| bad_en_i | input | 4 | Per-input enable of the bad indicator |
| bad_pol_i | input | 1 | Bad indicator polarity, 1 = active high |
| sel_o | output | 2 | Code of the current source |
| act_stat_o | output | 4 | Register copy of the active status, one-hot |
| holdover_o | output | 1 | Automatic mode with no valid input |
| los_o | output | 4 | Per-input loss-of-signal flags |
| act_pin_o | output | 4 | Active indicator pin values |
| act_pin_oe_o | output | 4 | Active indicator drive enables |
| bad_pin_o | output | 4 | Bad indicator pin values |
| bad_pin_oe_o | output | 4 | Bad indicator drive enables |

## Verification
The hardest state to reach is non-revertive operation on a lower-priority input after the preferred input has recovered. The stimulus gets there by stopping input 1 in non-revertive mode and restarting it. It then waits past the clear window and checks that the selection stays put. Only after that is the current input stopped, to see the fall back. Holdover is reached deterministically by first stopping the three lower-priority references and only then the selected one, so the frozen selection is known. Each loss boundary is approached with references whose edge spacing lies just inside or outside the limit.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    localparam int NUM_REF     = 4;
    localparam int SEL_W       = $clog2(NUM_REF);
    // first index whose indicator shares a pad with the select pins
    localparam int SHARED_BASE = NUM_REF - SEL_W;

    typedef enum logic [1:0] {
        MODE_MANUAL = 2'b00,
        MODE_REVERT = 2'b01,
        MODE_NONREV = 2'b10,
        MODE_MANALT = 2'b11
    } sel_mode_e;
endpackage

// File: rtl/refsel_los_mon.sv
module refsel_los_mon #(
    parameter int CNT_W  = 16,
    parameter int CLR_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [CLR_W-1:0] clear_i,
    output logic             los_o
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              prev;
        logic [CNT_W-1:0]  gap;
        logic [CLR_W-1:0]  good;
        logic              los;
    } mon_t;

    mon_t             r_d, r_q;
    logic             rise_w;
    logic [CNT_W-1:0] gap_inc;
    logic [CLR_W:0]   good_inc;

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[SYNC_N-2:0], ref_i};
        r_d.prev = r_q.sync[SYNC_N-1];
        rise_w   = r_q.sync[SYNC_N-1] & ~r_q.prev;
        gap_inc  = (r_q.gap >= limit_i) ? r_q.gap : r_q.gap + 1'b1;
        good_inc = {1'b0, r_q.good} + 1'b1;
        if (rise_w) begin
            r_d.gap = '0;
            if (r_q.los) begin
                if (r_q.gap < limit_i) begin
                    if (good_inc >= {1'b0, clear_i}) begin
                        r_d.los  = 1'b0;
                        r_d.good = '0;
                    end else begin
                        r_d.good = good_inc[CLR_W-1:0];
                    end
                end else begin
                    r_d.good = '0;
                end
            end
        end else begin
            r_d.gap = gap_inc;
            if (gap_inc >= limit_i) begin
                r_d.los  = 1'b1;
                r_d.good = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sync <= '0;
            r_q.prev <= 1'b0;
            r_q.gap  <= '1;
            r_q.good <= '0;
            r_q.los  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign los_o = r_q.los;
endmodule

// File: rtl/refsel_arbiter.sv
module refsel_arbiter
    import refsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic               pin_sel_en_i,
    input  logic [SEL_W-1:0]   sel_pin_i,
    input  logic [SEL_W-1:0]   reg_sel_i,
    input  logic [NUM_REF-1:0] los_i,
    output logic [SEL_W-1:0]   sel_o,
    output logic               holdover_o
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             hold;
    } arb_t;

    arb_t               r_d, r_q;
    logic [NUM_REF-1:0] valid_w;
    logic               any_w;
    logic [SEL_W-1:0]   first_w;
    sel_mode_e          mode_w;

    always_comb begin
        mode_w  = sel_mode_e'(mode_i);
        valid_w = ~los_i;
        any_w   = |valid_w;
        first_w = '0;
        for (int i = NUM_REF - 1; i >= 0; i--) begin
            if (valid_w[i]) first_w = SEL_W'(i);
        end

        r_d = r_q;
        unique case (mode_w)
            MODE_REVERT: begin
                r_d.hold = ~any_w;
                if (any_w) r_d.sel = first_w;
            end
            MODE_NONREV: begin
                r_d.hold = ~any_w;
                if (!valid_w[r_q.sel] && any_w) r_d.sel = first_w;
            end
            default: begin
                r_d.hold = 1'b0;
                r_d.sel  = pin_sel_en_i ? sel_pin_i : reg_sel_i;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sel  <= '0;
            r_q.hold <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_o      = r_q.sel;
    assign holdover_o = r_q.hold;
endmodule

// File: rtl/refsel_ind.sv
module refsel_ind
    import refsel_pkg::*;
(
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_REF-1:0] los_i,
    input  logic               auto_i,
    input  logic [NUM_REF-1:0] act_en_i,
    input  logic               act_pol_i,
    input  logic [NUM_REF-1:0] bad_en_i,
    input  logic               bad_pol_i,
    output logic [NUM_REF-1:0] act_stat_o,
    output logic [NUM_REF-1:0] act_pin_o,
    output logic [NUM_REF-1:0] act_pin_oe_o,
    output logic [NUM_REF-1:0] bad_pin_o,
    output logic [NUM_REF-1:0] bad_pin_oe_o
);
    for (genvar g = 0; g < NUM_REF; g++) begin : g_ind
        logic act_w;
        logic act_lvl_w;
        logic bad_lvl_w;

        assign act_w         = (sel_i == SEL_W'(g));
        assign act_stat_o[g] = act_w;
        assign act_lvl_w     = act_pol_i ? act_w : ~act_w;
        assign bad_lvl_w     = bad_pol_i ? los_i[g] : ~los_i[g];

        if (g >= SHARED_BASE) begin : g_shared
            assign act_pin_oe_o[g] = act_en_i[g] & auto_i;
        end else begin : g_own
            assign act_pin_oe_o[g] = act_en_i[g];
        end

        assign act_pin_o[g]    = act_pin_oe_o[g] & act_lvl_w;
        assign bad_pin_oe_o[g] = bad_en_i[g];
        assign bad_pin_o[g]    = bad_en_i[g] & bad_lvl_w;
    end
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector
    import refsel_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CLR_W  = 4,
    parameter int SYNC_N = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REF-1:0] ref_clk_i,
    input  logic [1:0]         mode_i,
    input  logic               pin_sel_en_i,
    input  logic [SEL_W-1:0]   sel_pin_i,
    input  logic [SEL_W-1:0]   reg_sel_i,
    input  logic [CNT_W-1:0]   los_limit_i,
    input  logic [CLR_W-1:0]   los_clear_i,
    input  logic [NUM_REF-1:0] act_en_i,
    input  logic               act_pol_i,
    input  logic [NUM_REF-1:0] bad_en_i,
    input  logic               bad_pol_i,
    output logic [SEL_W-1:0]   sel_o,
    output logic [NUM_REF-1:0] act_stat_o,
    output logic               holdover_o,
    output logic [NUM_REF-1:0] los_o,
    output logic [NUM_REF-1:0] act_pin_o,
    output logic [NUM_REF-1:0] act_pin_oe_o,
    output logic [NUM_REF-1:0] bad_pin_o,
    output logic [NUM_REF-1:0] bad_pin_oe_o
);
    logic auto_w;

    assign auto_w = (mode_i == MODE_REVERT) || (mode_i == MODE_NONREV);

    for (genvar g = 0; g < NUM_REF; g++) begin : g_mon
        refsel_los_mon #(
            .CNT_W (CNT_W),
            .CLR_W (CLR_W),
            .SYNC_N(SYNC_N)
        ) i_mon (
            .clk    (clk),
            .rst_n  (rst_n),
            .ref_i  (ref_clk_i[g]),
            .limit_i(los_limit_i),
            .clear_i(los_clear_i),
            .los_o  (los_o[g])
        );
    end

    refsel_arbiter i_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .pin_sel_en_i(pin_sel_en_i),
        .sel_pin_i   (sel_pin_i),
        .reg_sel_i   (reg_sel_i),
        .los_i       (los_o),
        .sel_o       (sel_o),
        .holdover_o  (holdover_o)
    );

    refsel_ind i_ind (
        .sel_i       (sel_o),
        .los_i       (los_o),
        .auto_i      (auto_w),
        .act_en_i    (act_en_i),
        .act_pol_i   (act_pol_i),
        .bad_en_i    (bad_en_i),
        .bad_pol_i   (bad_pol_i),
        .act_stat_o  (act_stat_o),
        .act_pin_o   (act_pin_o),
        .act_pin_oe_o(act_pin_oe_o),
        .bad_pin_o   (bad_pin_o),
        .bad_pin_oe_o(bad_pin_oe_o)
    );
endmodule

// File: rtl/refclk_selector_chk.sv
module refclk_selector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       pin_sel_en_i,
    input logic [1:0] sel_pin_i,
    input logic [1:0] reg_sel_i,
    input logic [3:0] act_en_i,
    input logic [3:0] los_o,
    input logic [1:0] sel_o,
    input logic       holdover_o,
    input logic [3:0] act_pin_oe_o
);
    logic [3:0] below_m;
    logic       auto_w;

    assign below_m = (4'd1 << sel_o) - 4'd1;
    assign auto_w  = (mode_i == 2'b01) || (mode_i == 2'b10);

    // R3
    pin_select_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == 2'b00 && $past(pin_sel_en_i)) |-> (sel_o == $past(sel_pin_i)));

    // R4
    reg_select_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == 2'b00 && !$past(pin_sel_en_i)) |-> (sel_o == $past(reg_sel_i)));

    // R7
    revert_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == 2'b01 && !holdover_o) |->
        (((~$past(los_o)) & below_m) == 4'd0 && (($past(los_o) >> sel_o) & 4'd1) == 4'd0));

    // R8
    nonrev_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == 2'b10 && !$past(los_o[sel_o])) |-> $stable(sel_o));

    // R9
    holdover_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(auto_w) && $past(&los_o)) |-> (holdover_o && $stable(sel_o)));

    // R11
    shared_pad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_w |-> (act_pin_oe_o[3:2] == 2'b00));

    // R10
    act_enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_pin_oe_o & ~act_en_i) == 4'd0);
endmodule

bind refclk_selector refclk_selector_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .pin_sel_en_i(pin_sel_en_i),
    .sel_pin_i   (sel_pin_i),
    .reg_sel_i   (reg_sel_i),
    .act_en_i    (act_en_i),
    .los_o       (los_o),
    .sel_o       (sel_o),
    .holdover_o  (holdover_o),
    .act_pin_oe_o(act_pin_oe_o)
);

// File: tb/test_refclk_selector.sv
module test_refclk_selector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ref_clk = 4'b0000;
    logic [1:0]  mode = 2'b00;
    logic        pin_sel_en = 1'b0;
    logic [1:0]  sel_pin = 2'b00;
    logic [1:0]  reg_sel = 2'b00;
    logic [15:0] los_limit = 16'd20;
    logic [3:0]  los_clear = 4'd3;
    logic [3:0]  act_en = 4'hF;
    logic        act_pol = 1'b1;
    logic [3:0]  bad_en = 4'hF;
    logic        bad_pol = 1'b1;
    logic [1:0]  sel;
    logic [3:0]  act_stat;
    logic        holdover;
    logic [3:0]  los;
    logic [3:0]  act_pin, act_pin_oe, bad_pin, bad_pin_oe;

    int half [4] = '{0, 0, 0, 0};
    int gcnt [4] = '{0, 0, 0, 0};
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    refclk_selector i_refclk_selector (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .mode_i(mode),
        .pin_sel_en_i(pin_sel_en), .sel_pin_i(sel_pin), .reg_sel_i(reg_sel),
        .los_limit_i(los_limit), .los_clear_i(los_clear),
        .act_en_i(act_en), .act_pol_i(act_pol), .bad_en_i(bad_en), .bad_pol_i(bad_pol),
        .sel_o(sel), .act_stat_o(act_stat), .holdover_o(holdover), .los_o(los),
        .act_pin_o(act_pin), .act_pin_oe_o(act_pin_oe),
        .bad_pin_o(bad_pin), .bad_pin_oe_o(bad_pin_oe)
    );

    // reference generators: half period in system cycles, 0 = stopped low
    initial begin
        forever begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (half[i] == 0) begin
                    ref_clk[i] = 1'b0;
                    gcnt[i] = 0;
                end else begin
                    gcnt[i]++;
                    if (gcnt[i] >= half[i]) begin
                        ref_clk[i] = ~ref_clk[i];
                        gcnt[i] = 0;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_cyc(3);
        chk("R1 sel in reset", 32'(sel), 32'h0);
        chk("R1 los in reset", 32'(los), 32'hF);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 sel after reset", 32'(sel), 32'h0);
        chk("R1 los after reset", 32'(los), 32'hF);
        chk("R1 holdover after reset", 32'(holdover), 32'h0);
        chk("R2 one-hot for code 00", 32'(act_stat), 32'h1);
    endtask

    task automatic t_los_clear();
        for (int i = 0; i < 4; i++) half[i] = 4;
        wait_cyc(18);
        chk("R6 still lost after two edges", 32'(los), 32'hF);
        wait_cyc(60);
        chk("R6 cleared after good intervals", 32'(los), 32'h0);
    endtask

    task automatic t_manual_reg();
        mode = 2'b00; pin_sel_en = 1'b0; reg_sel = 2'b10; sel_pin = 2'b01;
        wait_cyc(3);
        chk("R4 register code 10", 32'(sel), 32'h2);
        chk("R2 status for input 3", 32'(act_stat), 32'h4);
        sel_pin = 2'b11;
        wait_cyc(3);
        chk("R4 select pins ignored", 32'(sel), 32'h2);
        chk("R11 shared pads undriven in manual", 32'(act_pin_oe[3:2]), 32'h0);
        reg_sel = 2'b11;
        wait_cyc(3);
        chk("R2 code 11 gives input 4", 32'(act_stat), 32'h8);
    endtask

    task automatic t_manual_pin();
        pin_sel_en = 1'b1; sel_pin = 2'b01; reg_sel = 2'b11;
        wait_cyc(3);
        chk("R3 pin code 01", 32'(sel), 32'h1);
        chk("R2 status for input 2", 32'(act_stat), 32'h2);
        reg_sel = 2'b00;
        wait_cyc(3);
        chk("R3 register bits ignored", 32'(sel), 32'h1);
        mode = 2'b11;
        sel_pin = 2'b00;
        wait_cyc(3);
        chk("R3 mode 11 acts manual", 32'(sel), 32'h0);
        mode = 2'b00;
    endtask

    task automatic t_los_detect();
        half[3] = 12;
        half[2] = 9;
        wait_cyc(100);
        chk("R5 gap 24 over limit 20 lost, gap 18 kept", 32'(los), 32'h8);
        half[2] = 4; half[3] = 4;
        wait_cyc(100);
        chk("R6 recovered after restore", 32'(los), 32'h0);
    endtask

    task automatic t_revert();
        mode = 2'b01;
        wait_cyc(3);
        chk("R7 revertive picks input 1", 32'(sel), 32'h0);
        chk("R9 no holdover", 32'(holdover), 32'h0);
        chk("R11 shared pads driven in auto", 32'(act_pin_oe), 32'hF);
        chk("R10 active high pins", 32'(act_pin), 32'h1);
        act_pol = 1'b0;
        wait_cyc(1);
        chk("R10 active low pins", 32'(act_pin), 32'hE);
        act_en = 4'b0101;
        wait_cyc(1);
        chk("R10 enables follow", 32'(act_pin_oe), 32'h5);
        chk("R10 undriven pins read 0", 32'(act_pin), 32'h4);
        act_en = 4'hF; act_pol = 1'b1;
        half[0] = 0;
        wait_cyc(40);
        chk("R5 stopped input lost", 32'(los), 32'h1);
        chk("R7 moves to input 2", 32'(sel), 32'h1);
        chk("R12 bad pins active high", 32'(bad_pin), 32'h1);
        bad_pol = 1'b0;
        wait_cyc(1);
        chk("R12 bad pins active low", 32'(bad_pin), 32'hE);
        bad_en = 4'b0000;
        wait_cyc(1);
        chk("R12 bad enables clear", 32'(bad_pin_oe), 32'h0);
        chk("R12 undriven bad pins read 0", 32'(bad_pin), 32'h0);
        bad_en = 4'hF; bad_pol = 1'b1;
        half[0] = 4;
        wait_cyc(60);
        chk("R7 returns to input 1", 32'(sel), 32'h0);
    endtask

    task automatic t_nonrev();
        mode = 2'b10;
        wait_cyc(3);
        chk("R8 keeps input 1", 32'(sel), 32'h0);
        half[0] = 0;
        wait_cyc(40);
        chk("R8 fails over to input 2", 32'(sel), 32'h1);
        half[0] = 4;
        wait_cyc(60);
        chk("R8 input 1 recovered", 32'(los), 32'h0);
        chk("R8 stays on input 2", 32'(sel), 32'h1);
        half[1] = 0;
        wait_cyc(40);
        chk("R8 falls back to lowest valid", 32'(sel), 32'h0);
        half[1] = 4;
        wait_cyc(60);
    endtask

    task automatic t_holdover();
        mode = 2'b01;
        half[1] = 0; half[2] = 0; half[3] = 0;
        wait_cyc(40);
        chk("R7 input 1 still used", 32'(sel), 32'h0);
        half[0] = 0;
        wait_cyc(40);
        chk("R9 holdover raised", 32'(holdover), 32'h1);
        chk("R9 selection frozen", 32'(sel), 32'h0);
        mode = 2'b00; pin_sel_en = 1'b1; sel_pin = 2'b01;
        wait_cyc(3);
        chk("R9 no holdover in manual", 32'(holdover), 32'h0);
        mode = 2'b01;
        half[2] = 4;
        wait_cyc(60);
        chk("R9 leaves holdover", 32'(holdover), 32'h0);
        chk("R7 picks only valid input 3", 32'(sel), 32'h2);
    endtask

    initial begin
        t_reset();
        t_los_clear();
        t_manual_reg();
        t_manual_pin();
        t_los_detect();
        t_revert();
        t_nonrev();
        t_holdover();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule